// File: doc/BRIEF.md
# Four-Stage In-Order Pipeline with Hazard Control

This block is a small integer pipeline. Instructions move through four stages in a fixed order: fetch, decode with register read, execute, and write-back. Three interstage registers separate the stages. With no hazard, each stage takes one clock, and one instruction retires per clock. Control logic inserts stalls and bubbles in three situations: when a decode-stage instruction needs a result that is not yet available, when a multiply holds the execute stage for several cycles, and when instruction memory is slow to answer. A taken branch is resolved in decode, and the instruction fetched behind it is discarded.

Instructions are 32 bits wide. The opcode is in [31:28], the destination register in [27:24], the first source in [23:20], the second source in [19:16] and a 16-bit immediate in [15:0]. Fetch drives `imem_req` together with `imem_addr`. An instruction is transferred in a cycle where `imem_req` and `imem_ready` are both high, and `imem_rdata` must then hold the word at that address. The memory applies back-pressure by holding `imem_ready` low. The core keeps the address steady while it waits, unless a branch redirects fetch. While decode is stalled the core drops `imem_req`, which withdraws the request, so the memory must not rely on a request staying up. Each register write is shown on the write-back observation port in the cycle the register file takes it. The `forward_en` pin selects between forwarding mode and interlock-only mode.

Top module: `pipe4_core`

## Requirements
- R1: The sequence of (register, value) pairs on the write-back port matches sequential execution of the same program in both modes and for any `imem_ready` pattern. Registers start at zero after reset. ADD, SUB and MUL (product truncated to the data width) use two sources. ADDI adds a sign-extended immediate to one source.
- R2: A run of independent instructions fetched with `imem_ready` high retires one per cycle, so consecutive write-backs are 1 cycle apart.
- R3: MUL (opcode 3) stays in execute for 3 cycles and the instructions behind it hold their stages. A MUL whose operand is forwarded writes back 3 cycles after its producer. The independent instruction behind the MUL retires 1 cycle after it.
- R4: In each cycle with `imem_req` high and `imem_ready` low, the fetch address is held and decode receives a bubble. Two back-to-back instructions with N wait states on the second retire N+1 cycles apart.
- R5: With `forward_en` low, an instruction that reads the destination of the instruction just ahead of it waits in decode until that write-back, and retires 2 cycles after it.
- R6: With `forward_en` high, the result register feeds the execute operands, and the same dependent pair retires 1 cycle apart.
- R7: A branch (opcode 5) jumps to the absolute address in the low address bits of its immediate. The instruction fetched right after it never writes back. The target's write-back comes 3 cycles after that of the instruction before the branch.
- R8: Register 0 reads as zero. A write to it produces no write-back event and creates no interlock or forward.
- R9: While reset is high, `wb_valid` and `imem_req` are low. In the first cycle after reset, `imem_req` is high and `imem_addr` is 0.
- R10: Opcode 0 and every opcode above 5 act as NOP: they write nothing and add no delay of their own. The ADDI immediate is sign-extended (0xFFFD adds -3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| forward_en | input | 1 | 1 = forwarding mode, 0 = interlock only |
| imem_req | output | 1 | Fetch request valid |
| imem_addr | output | PC_W | Fetch address (program counter) |
| imem_ready | input | 1 | Memory has the word for this cycle |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| wb_valid | output | 1 | A register write happens this cycle |
| wb_rd | output | 4 | Register being written |
| wb_data | output | DATA_W | Value being written |

## Verification
The embedded properties assume that `forward_en` changes only while reset is asserted. If it flips mid-run, an instruction that entered execute under forwarding rules could meet the interlock-mode property. They also assume that `imem_rdata` is defined whenever a transfer happens. The bench sets the mode only inside its reset sequence. Its instruction memory always answers from an array filled with NOPs and a final self-branch, so fetch never reads an undefined word. Wait states come either from a per-address counter or from a pseudo-random bit. Both are updated just after a clock edge, so `imem_ready` is stable across each sampling edge.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;
  localparam int INSTR_W = 32;
  localparam int NREG    = 16;
  localparam int REG_AW  = 4;
  localparam int IMM_W   = 16;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_MUL  = 4'd3,
    OP_ADDI = 4'd4,
    OP_BR   = 4'd5
  } op_e;

  typedef struct packed {
    logic [3:0]        opc;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] rs1;
    logic [REG_AW-1:0] rs2;
    logic [IMM_W-1:0]  imm;
  } instr_t;
endpackage

// File: rtl/pipe4_regfile.sv
module pipe4_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  parameter int NRD    = 2,
  localparam int AW    = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0]     raddr,
  output logic [NRD-1:0][DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  // write-through: a read in the write cycle sees the new value
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (raddr[p] == '0)                 rdata[p] = '0;
      else if (we && waddr == raddr[p])   rdata[p] = wdata;
      else                                rdata[p] = regs[raddr[p]];
    end
  end
endmodule

// File: rtl/pipe4_exec.sv
module pipe4_exec import pipe4_pkg::*; #(
  parameter int DATA_W  = 32,
  parameter int MUL_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] result,
  output logic              busy
);
  localparam int CW = (MUL_CYC > 1) ? $clog2(MUL_CYC) : 1;

  logic [CW-1:0] cnt;
  logic          is_mul;

  assign is_mul = valid && (op == OP_MUL);
  assign busy   = is_mul && (cnt != CW'(MUL_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (busy) cnt <= cnt + 1'b1;
    else           cnt <= '0;
  end

  always_comb begin
    case (op)
      OP_ADD:  result = a + b;
      OP_SUB:  result = a - b;
      OP_MUL:  result = a * b;
      OP_ADDI: result = a + imm;
      default: result = '0;
    endcase
  end

  if (MUL_CYC > 1) begin : g_mul_chk
    // R3: once a multiply starts, the stage keeps it for the next cycle
    assert_mul_held_R3: assert property (@(posedge clk) disable iff (rst)
      (is_mul && cnt == '0) |=> (valid && op == OP_MUL));
  end
endmodule

// File: rtl/pipe4_hazard.sv
module pipe4_hazard #(
  parameter int AW = 4
) (
  input  logic          forward_en,
  input  logic          d_valid,
  input  logic          d_u1,
  input  logic          d_u2,
  input  logic [AW-1:0] d_rs1,
  input  logic [AW-1:0] d_rs2,
  input  logic          e_valid,
  input  logic          e_we,
  input  logic [AW-1:0] e_rd,
  input  logic          e_u1,
  input  logic          e_u2,
  input  logic [AW-1:0] e_rs1,
  input  logic [AW-1:0] e_rs2,
  input  logic          w_valid,
  input  logic          w_we,
  input  logic [AW-1:0] w_rd,
  input  logic          e_busy,
  output logic          stall_d,
  output logic          fwd_a,
  output logic          fwd_b
);
  logic raw;
  logic w_live;

  assign raw = !forward_en && d_valid && e_valid && e_we &&
               ((d_u1 && d_rs1 == e_rd) || (d_u2 && d_rs2 == e_rd));
  assign stall_d = e_busy || raw;

  assign w_live = forward_en && w_valid && w_we;
  assign fwd_a  = w_live && e_valid && e_u1 && (e_rs1 == w_rd);
  assign fwd_b  = w_live && e_valid && e_u2 && (e_rs2 == w_rd);
endmodule

// File: rtl/pipe4_core.sv
module pipe4_core import pipe4_pkg::*; #(
  parameter int DATA_W  = 32,
  parameter int PC_W    = 6,
  parameter int MUL_CYC = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               forward_en,
  output logic               imem_req,
  output logic [PC_W-1:0]    imem_addr,
  input  logic               imem_ready,
  input  logic [INSTR_W-1:0] imem_rdata,
  output logic               wb_valid,
  output logic [REG_AW-1:0]  wb_rd,
  output logic [DATA_W-1:0]  wb_data
);
  localparam int EXT_W = DATA_W - IMM_W;

  // fetch / decode buffer
  logic [PC_W-1:0]    pc;
  logic               fd_valid;
  logic [INSTR_W-1:0] fd_instr;
  // decode / execute buffer
  logic               de_valid, de_we, de_u1, de_u2;
  op_e                de_op;
  logic [REG_AW-1:0]  de_rd, de_rs1, de_rs2;
  logic [DATA_W-1:0]  de_a, de_b, de_imm;
  // execute / write-back buffer (result register)
  logic               ew_valid, ew_we;
  logic [REG_AW-1:0]  ew_rd;
  logic [DATA_W-1:0]  ew_data;

  // decode
  instr_t             d_in;
  op_e                d_op;
  logic               d_alu, d_u1, d_u2, d_we;
  logic [DATA_W-1:0]  d_imm;
  logic [PC_W-1:0]    d_target;
  logic [1:0][DATA_W-1:0] rf_rdata;

  assign d_in = instr_t'(fd_instr);

  always_comb begin
    case (d_in.opc)
      OP_ADD, OP_SUB, OP_MUL, OP_ADDI, OP_BR: d_op = op_e'(d_in.opc);
      default:                                d_op = OP_NOP;
    endcase
  end

  assign d_alu    = (d_op == OP_ADD) || (d_op == OP_SUB) ||
                    (d_op == OP_MUL) || (d_op == OP_ADDI);
  assign d_u1     = d_alu && (d_in.rs1 != '0);
  assign d_u2     = d_alu && (d_op != OP_ADDI) && (d_in.rs2 != '0);
  assign d_we     = d_alu && (d_in.rd != '0);
  assign d_imm    = {{EXT_W{d_in.imm[IMM_W-1]}}, d_in.imm};
  assign d_target = d_in.imm[PC_W-1:0];

  pipe4_regfile #(.DATA_W(DATA_W), .NREG(NREG), .NRD(2)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (ew_valid && ew_we),
    .waddr (ew_rd),
    .wdata (ew_data),
    .raddr ({d_in.rs2, d_in.rs1}),
    .rdata (rf_rdata)
  );

  // hazard control
  logic e_busy, stall_d, fwd_a, fwd_b, br_take;

  pipe4_hazard #(.AW(REG_AW)) u_hz (
    .forward_en (forward_en),
    .d_valid    (fd_valid),
    .d_u1       (d_u1),
    .d_u2       (d_u2),
    .d_rs1      (d_in.rs1),
    .d_rs2      (d_in.rs2),
    .e_valid    (de_valid),
    .e_we       (de_we),
    .e_rd       (de_rd),
    .e_u1       (de_u1),
    .e_u2       (de_u2),
    .e_rs1      (de_rs1),
    .e_rs2      (de_rs2),
    .w_valid    (ew_valid),
    .w_we       (ew_we),
    .w_rd       (ew_rd),
    .e_busy     (e_busy),
    .stall_d    (stall_d),
    .fwd_a      (fwd_a),
    .fwd_b      (fwd_b)
  );

  assign br_take = fd_valid && (d_op == OP_BR) && !stall_d;

  // execute
  logic [DATA_W-1:0] e_a, e_b, e_result;
  assign e_a = fwd_a ? ew_data : de_a;
  assign e_b = fwd_b ? ew_data : de_b;

  pipe4_exec #(.DATA_W(DATA_W), .MUL_CYC(MUL_CYC)) u_ex (
    .clk    (clk),
    .rst    (rst),
    .valid  (de_valid),
    .op     (de_op),
    .a      (e_a),
    .b      (e_b),
    .imm    (de_imm),
    .result (e_result),
    .busy   (e_busy)
  );

  // pipeline registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      fd_valid <= 1'b0;
      de_valid <= 1'b0;
      ew_valid <= 1'b0;
    end else begin
      ew_valid <= de_valid && !e_busy;
      ew_we    <= de_we;
      ew_rd    <= de_rd;
      ew_data  <= e_result;

      if (e_busy) begin
        de_a <= e_a;          // keep a forwarded operand across the hold
        de_b <= e_b;
      end else if (stall_d) begin
        de_valid <= 1'b0;
      end else begin
        de_valid <= fd_valid;
        de_op    <= d_op;
        de_we    <= d_we;
        de_u1    <= d_u1;
        de_u2    <= d_u2;
        de_rd    <= d_in.rd;
        de_rs1   <= d_in.rs1;
        de_rs2   <= d_in.rs2;
        de_a     <= rf_rdata[0];
        de_b     <= rf_rdata[1];
        de_imm   <= d_imm;
      end

      if (!stall_d) begin
        if (br_take) begin
          pc       <= d_target;
          fd_valid <= 1'b0;
        end else if (imem_ready) begin
          pc       <= pc + 1'b1;
          fd_valid <= 1'b1;
          fd_instr <= imem_rdata;
        end else begin
          fd_valid <= 1'b0;
        end
      end
    end
  end

  assign imem_req  = !rst && !stall_d;
  assign imem_addr = pc;
  assign wb_valid  = ew_valid && ew_we;
  assign wb_rd     = ew_rd;
  assign wb_data   = ew_data;

  // R4: a waiting fetch keeps its address and sends a bubble
  assert_fetch_wait_R4: assert property (@(posedge clk) disable iff (rst)
    (imem_req && !imem_ready && !br_take) |=> ($stable(imem_addr) && !fd_valid));
  // R7: a taken branch squashes the fetched word and redirects
  assert_branch_squash_R7: assert property (@(posedge clk) disable iff (rst)
    br_take |=> (!fd_valid && imem_addr == $past(d_target)));
  // R5: in interlock mode no consumer sits in execute next to its producer
  assert_interlock_R5: assert property (@(posedge clk) disable iff (rst)
    (!forward_en && de_valid && ew_valid && ew_we) |->
      (!(de_u1 && de_rs1 == ew_rd) && !(de_u2 && de_rs2 == ew_rd)));
  // R8: no write to register 0 reaches write-back
  assert_no_r0_write_R8: assert property (@(posedge clk) disable iff (rst)
    (ew_valid && ew_we) |-> (ew_rd != '0));
  // R2: execute drains into write-back whenever it is not held
  assert_exec_drains_R2: assert property (@(posedge clk) disable iff (rst)
    (de_valid && !e_busy) |=> ew_valid);
endmodule

// File: tb/pipe4_core_tb.sv
`timescale 1ns/1ps
module pipe4_core_tb;
  localparam int PCW = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fwd = 1'b0;
  logic        imem_req, imem_ready, wb_valid;
  logic [PCW-1:0] imem_addr;
  logic [31:0] imem_rdata, wb_data;
  logic [3:0]  wb_rd;

  logic [31:0] mem [64];
  int          n_cmp = 0, n_bad = 0, cyc = 0;
  logic [3:0]  exp_rd [$];
  logic [31:0] exp_dat [$];
  int          stamps [$];
  int          wait_addr = -1, wait_left = 0;
  bit          rnd_mode = 0, rnd_stall = 0;
  logic [31:0] lf = 32'h1234_5679, pg = 32'h0BAD_F00D;

  assign imem_rdata = mem[imem_addr];
  assign imem_ready = !(imem_req && int'(imem_addr) == wait_addr && wait_left != 0) && !rnd_stall;

  pipe4_core #(.DATA_W(32), .PC_W(PCW), .MUL_CYC(3)) u_dut (
    .clk(clk), .rst(rst), .forward_en(fwd),
    .imem_req(imem_req), .imem_addr(imem_addr), .imem_ready(imem_ready), .imem_rdata(imem_rdata),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data));

  initial forever #2 clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
    if (imem_req && int'(imem_addr) == wait_addr && wait_left != 0) wait_left <= wait_left - 1;
    lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
    rnd_stall <= rnd_mode && (lf[1:0] == 2'b00);
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R1: watchdog expired, actual %0d cycles, expected fewer", cyc);
    summary();
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference comparison on every clock (R1)
  initial forever begin
    @(negedge clk);
    if (!rst && wb_valid) begin
      stamps.push_back(cyc);
      if (exp_rd.size() == 0) begin
        chk(0, "R1 unexpected write", {wb_rd, wb_data[27:0]}, 32'h0);
      end else begin
        logic [3:0]  er;
        logic [31:0] ed;
        er = exp_rd.pop_front();
        ed = exp_dat.pop_front();
        chk(wb_rd == er, "R1 register", 32'(wb_rd), 32'(er));
        chk(wb_data == ed, "R1 value", wb_data, ed);
      end
    end
  end

  function automatic logic [31:0] enc(input int op, input int rd, input int a, input int b, input int imm);
    return {op[3:0], rd[3:0], a[3:0], b[3:0], imm[15:0]};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[63] = enc(5, 0, 0, 0, 63);
    wait_addr = -1; wait_left = 0; rnd_mode = 0;
  endtask

  // sequential instruction-set model
  task automatic build_expect();
    logic [31:0] r [16];
    int pc, n;
    for (int i = 0; i < 16; i++) r[i] = '0;
    exp_rd.delete(); exp_dat.delete();
    pc = 0; n = 0;
    while (pc != 63 && n < 2000) begin
      logic [31:0] w, x, sx;
      int op, rd, a, b;
      bit wr;
      w = mem[pc]; op = int'(w[31:28]); rd = int'(w[27:24]);
      a = int'(w[23:20]); b = int'(w[19:16]);
      sx = {{16{w[15]}}, w[15:0]}; x = '0; wr = 1; pc++;
      case (op)
        1: x = r[a] + r[b];
        2: x = r[a] - r[b];
        3: x = r[a] * r[b];
        4: x = r[a] + sx;
        5: begin pc = int'(w[5:0]); wr = 0; end
        default: wr = 0;
      endcase
      if (wr && rd != 0) begin
        r[rd] = x;
        exp_rd.push_back(rd[3:0]);
        exp_dat.push_back(x);
      end
      n++;
    end
  endtask

  task automatic run(input bit f, input int ncyc);
    build_expect();
    stamps.delete();
    @(negedge clk); rst = 1'b1; fwd = f;
    repeat (2) @(negedge clk);
    chk(!wb_valid && !imem_req, "R9 idle in reset", {wb_valid, imem_req}, 32'h0);
    rst = 1'b0;
    #1;
    chk(imem_req && imem_addr == '0, "R9 first fetch", {imem_req, 26'h0, imem_addr}, 32'h8000_0000);
    repeat (ncyc) @(negedge clk);
    chk(exp_rd.size() == 0, "R1 all writes retired", exp_rd.size(), 32'h0);
  endtask

  task automatic gap(input int i, input int g, input string tag);
    if (stamps.size() <= i) chk(0, tag, stamps.size(), i + 1);
    else chk(stamps[i] - stamps[i-1] == g, tag, stamps[i] - stamps[i-1], g);
  endtask

  task automatic rand_prog();
    clear_mem();
    for (int i = 0; i < 40; i++) begin
      int k, rd, a, b;
      pg = pg ^ (pg << 13); pg = pg ^ (pg >> 17); pg = pg ^ (pg << 5);
      k = int'(pg[2:0]); rd = int'(pg[5:3]); a = int'(pg[8:6]); b = int'(pg[11:9]);
      case (k)
        0, 4: mem[i] = enc(4, rd, a, 0, int'(pg[31:20]) - 2048);
        1, 6: mem[i] = enc(1, rd, a, b, 0);
        2:    mem[i] = enc(2, rd, a, b, 0);
        3:    mem[i] = enc(3, rd, a, b, 0);
        5:    mem[i] = enc(5, 0, 0, 0, i + 1 + int'(pg[13:12]) % 3);
        default: mem[i] = enc(0, 0, 0, 0, 0);
      endcase
    end
  endtask

  initial begin
    // R2: independent instructions, one per cycle
    for (int f = 0; f < 2; f++) begin
      clear_mem();
      for (int i = 0; i < 4; i++) mem[i] = enc(4, i + 1, 0, 0, i + 1);
      run(f[0], 30);
      gap(1, 1, "R2 gap1"); gap(2, 1, "R2 gap2"); gap(3, 1, "R2 gap3");
    end
    // R5 / R6: dependent chain
    clear_mem();
    mem[0] = enc(4, 1, 0, 0, 5); mem[1] = enc(1, 2, 1, 1, 0); mem[2] = enc(2, 3, 2, 1, 0);
    run(1'b1, 30); gap(1, 1, "R6 fwd gap1"); gap(2, 1, "R6 fwd gap2");
    run(1'b0, 30); gap(1, 2, "R5 interlock gap1"); gap(2, 2, "R5 interlock gap2");
    // R3: multiply hold
    clear_mem();
    mem[0] = enc(4, 1, 0, 0, 3); mem[1] = enc(3, 2, 1, 1, 0); mem[2] = enc(4, 3, 0, 0, 1);
    run(1'b1, 30); gap(1, 3, "R3 mul fwd"); gap(2, 1, "R3 after mul");
    run(1'b0, 30); gap(1, 4, "R3 mul interlock"); gap(2, 1, "R3 after mul interlock");
    mem[2] = enc(1, 4, 2, 1, 0);
    run(1'b1, 30); gap(2, 1, "R3 dep after mul fwd");
    run(1'b0, 30); gap(2, 2, "R3 dep after mul interlock");
    // R7: branch squash
    clear_mem();
    mem[0] = enc(4, 1, 0, 0, 1); mem[1] = enc(5, 0, 0, 0, 5);
    mem[2] = enc(4, 2, 0, 0, 2); mem[3] = enc(4, 3, 0, 0, 3); mem[5] = enc(4, 4, 0, 0, 4);
    run(1'b1, 30); gap(1, 3, "R7 branch penalty");
    // R4: fetch wait states
    clear_mem();
    mem[0] = enc(4, 1, 0, 0, 1); mem[1] = enc(4, 2, 0, 0, 2); mem[2] = enc(4, 3, 0, 0, 3);
    wait_addr = 1; wait_left = 2;
    run(1'b1, 30); gap(1, 3, "R4 two wait states"); gap(2, 1, "R4 resume");
    // R8: register 0
    clear_mem();
    mem[0] = enc(4, 1, 0, 0, 7); mem[1] = enc(4, 0, 0, 0, 5); mem[2] = enc(1, 2, 0, 1, 0);
    run(1'b0, 30); gap(1, 2, "R8 no r0 interlock");
    // R10: sign extension and unknown opcode
    clear_mem();
    mem[0] = enc(4, 1, 0, 0, 16'hFFFD); mem[1] = enc(15, 2, 1, 1, 9); mem[2] = enc(4, 3, 1, 0, 1);
    run(1'b0, 30); gap(1, 2, "R10 unknown opcode as NOP");
    // R1: random programs, both modes, random wait states
    for (int t = 0; t < 4; t++) begin
      rand_prog();
      rnd_mode = t[0];
      run(1'b1, 400);
      rnd_mode = t[0];
      run(1'b0, 400);
    end
    summary();
  end
endmodule